// File: doc/BRIEF.md
# Prioritized Dual-Queue Random Word Distributor

This block takes 32-bit random words from a single producer and spreads them over two output queues: a secure queue of eight words and a non-secure queue of four words. The secure queue has priority. Once it drops below half full (fewer than four words), every accepted word goes to it until it is full again. While that refill is pending the non-secure queue receives nothing. Outside a refill, words go to the non-secure queue while it has room, and the secure queue is not topped up.

Each queue is read through a single window. The window always shows the oldest word, or zero when the queue is empty. A read strobe on a non-empty queue removes that word; a read strobe on an empty queue changes nothing. Each side reports how many words it holds and an error flag.

A global error input flushes both queues. It latches an error state that holds both flags high and stops the producer until the next reset.

Top module: `rand_dist_fifos`

## Requirements
- R1: The secure queue holds up to 8 words and returns them in arrival order; `sec_count_o` gives its fill level, 0 to 8.
- R2: The non-secure queue holds up to 4 words and returns them in arrival order; `ns_count_o` gives its fill level, 0 to 4.
- R3: `*_rdata_o` shows the oldest word of a non-empty queue combinationally. A read strobe removes that word at the next clock edge.
- R4: When a queue is empty, its `*_rdata_o` is zero. A read strobe on an empty queue leaves its count unchanged.
- R5: When the secure count is below 4, an accepted word is written to the secure queue and no word is written to the non-secure queue.
- R6: Once a secure refill has started, accepted words keep going to the secure queue until its count reaches 8, even after the count is 4 or more.
- R7: Outside a refill, accepted words go only to the non-secure queue, and only while it holds fewer than 4 words. A secure queue holding 4 to 7 words is not topped up.
- R8: `prod_ready_o` is low when the queue eligible under R5 to R7 is full. A word is taken only in a cycle where `prod_valid_i` and `prod_ready_o` are both high.
- R9: A high `err_i` at a clock edge empties both queues and sets both error flags, which stay high until reset. While `err_i` is high or the error is latched, `prod_ready_o` is low.
- R10: After reset both counts are 0, both error flags are 0, `prod_ready_o` is 1 and both windows read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | Global error; flushes and latches the error state |
| prod_valid_i | input | 1 | Producer word valid |
| prod_data_i | input | 32 | Producer random word |
| prod_ready_o | output | 1 | Block accepts a word this cycle |
| sec_rd_i | input | 1 | Secure window read strobe |
| sec_rdata_o | output | 32 | Secure window: oldest word or zero |
| sec_count_o | output | 4 | Secure queue fill level in words |
| sec_err_o | output | 1 | Secure side error flag |
| ns_rd_i | input | 1 | Non-secure window read strobe |
| ns_rdata_o | output | 32 | Non-secure window: oldest word or zero |
| ns_count_o | output | 3 | Non-secure queue fill level in words |
| ns_err_o | output | 1 | Non-secure side error flag |

## Verification
Assertions check several properties on every cycle:
- no word is pushed into a full queue;
- the non-secure queue is starved while the secure count is below half, or while a refill is latched;
- at most one queue is written, and only on a valid/ready handshake;
- an empty read leaves the count alone;
- a latched error keeps both queues empty and stays set.

Only the bench scenarios can show the hysteresis itself. That means the refill running on past four words to eight, the secure queue left at four to seven words while the non-secure queue fills, and the exact word order through both windows. The bench covers these against a queue-based reference model that is compared every cycle.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int unsigned WORD_W = 32;
  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_SEC  = 2'd1,
    DEST_NS   = 2'd2
  } rdf_dest_e;
endpackage

// File: rtl/rdf_word_fifo.sv
module rdf_word_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign count_o = cnt_q;
  assign rdata_o = empty_o ? '0 : mem[rptr_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (do_push && (wptr_q == AW'(i))) mem[i] <= wdata_i;
    end
  end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R2
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  // R4
  empty_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> $stable(count_o));
endmodule

// File: rtl/rdf_route.sv
module rdf_route
  import rdf_pkg::*;
#(
  parameter int unsigned SEC_DEPTH = 8,
  parameter int unsigned NS_DEPTH  = 4,
  parameter int unsigned SEC_LOW   = SEC_DEPTH / 2,
  localparam int unsigned SCW = $clog2(SEC_DEPTH + 1),
  localparam int unsigned NCW = $clog2(NS_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           block_i,
  input  logic           valid_i,
  input  logic           sec_pop_i,
  input  logic [SCW-1:0] sec_count_i,
  input  logic [NCW-1:0] ns_count_i,
  output logic           ready_o,
  output logic           sec_push_o,
  output logic           ns_push_o
);
  logic      refill_q, refill_act, sec_full, ns_full;
  logic [SCW-1:0] sec_cnt_nxt;
  rdf_dest_e dest;

  assign sec_full   = (sec_count_i == SCW'(SEC_DEPTH));
  assign ns_full    = (ns_count_i == NCW'(NS_DEPTH));
  // hysteresis: enter below low mark, leave only at full
  assign refill_act = refill_q || (sec_count_i < SCW'(SEC_LOW));

  always_comb begin
    dest = DEST_NONE;
    if (!block_i) begin
      if (refill_act) begin
        if (!sec_full) dest = DEST_SEC;
      end else if (!ns_full) begin
        dest = DEST_NS;
      end
    end
  end

  assign ready_o     = (dest != DEST_NONE);
  assign sec_push_o  = valid_i && (dest == DEST_SEC);
  assign ns_push_o   = valid_i && (dest == DEST_NS);
  assign sec_cnt_nxt = sec_count_i + SCW'(sec_push_o) - SCW'(sec_pop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      refill_q <= 1'b0;
    else if (block_i) refill_q <= 1'b0;
    else              refill_q <= refill_act && (sec_cnt_nxt != SCW'(SEC_DEPTH));
  end

  // R5
  ns_starve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_count_i < SCW'(SEC_LOW)) |-> !ns_push_o);
  // R6
  refill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_q |-> !ns_push_o);
  // R8
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sec_push_o, ns_push_o}));
  // R8
  handshake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_push_o || ns_push_o) |-> (valid_i && ready_o));
endmodule

// File: rtl/rand_dist_fifos.sv
module rand_dist_fifos
  import rdf_pkg::*;
#(
  parameter int unsigned DW        = WORD_W,
  parameter int unsigned SEC_DEPTH = 8,
  parameter int unsigned NS_DEPTH  = 4,
  localparam int unsigned SCW = $clog2(SEC_DEPTH + 1),
  localparam int unsigned NCW = $clog2(NS_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           err_i,
  input  logic           prod_valid_i,
  input  logic [DW-1:0]  prod_data_i,
  output logic           prod_ready_o,
  input  logic           sec_rd_i,
  output logic [DW-1:0]  sec_rdata_o,
  output logic [SCW-1:0] sec_count_o,
  output logic           sec_err_o,
  input  logic           ns_rd_i,
  output logic [DW-1:0]  ns_rdata_o,
  output logic [NCW-1:0] ns_count_o,
  output logic           ns_err_o
);
  logic err_q, flush, sec_push, ns_push, sec_full, ns_full, sec_empty, ns_empty;
  logic sec_pop_eff;

  assign flush       = err_i || err_q;
  assign sec_pop_eff = sec_rd_i && !sec_empty && !flush;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (err_i) err_q <= 1'b1;
  end

  assign sec_err_o = err_q;
  assign ns_err_o  = err_q;

  rdf_route #(
    .SEC_DEPTH(SEC_DEPTH),
    .NS_DEPTH (NS_DEPTH)
  ) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .block_i    (flush),
    .valid_i    (prod_valid_i),
    .sec_pop_i  (sec_pop_eff),
    .sec_count_i(sec_count_o),
    .ns_count_i (ns_count_o),
    .ready_o    (prod_ready_o),
    .sec_push_o (sec_push),
    .ns_push_o  (ns_push)
  );

  rdf_word_fifo #(.DW(DW), .DEPTH(SEC_DEPTH)) u_sec_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .push_i (sec_push),
    .wdata_i(prod_data_i),
    .pop_i  (sec_rd_i),
    .rdata_o(sec_rdata_o),
    .count_o(sec_count_o),
    .full_o (sec_full),
    .empty_o(sec_empty)
  );

  rdf_word_fifo #(.DW(DW), .DEPTH(NS_DEPTH)) u_ns_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .push_i (ns_push),
    .wdata_i(prod_data_i),
    .pop_i  (ns_rd_i),
    .rdata_o(ns_rdata_o),
    .count_o(ns_count_o),
    .full_o (ns_full),
    .empty_o(ns_empty)
  );

  // R9
  err_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (sec_empty && ns_empty && !prod_ready_o));
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R4
  empty_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_empty |-> sec_rdata_o == '0) and (ns_empty |-> ns_rdata_o == '0));
  // R8
  ready_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_full && ns_full) |-> !prod_ready_o);
endmodule

// File: tb/tb_rand_dist_fifos.sv
module tb_rand_dist_fifos;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_i = 1'b0;
  logic        prod_valid_i = 1'b0;
  logic [31:0] prod_data_i = '0;
  logic        sec_rd_i = 1'b0, ns_rd_i = 1'b0;
  logic        prod_ready_o, sec_err_o, ns_err_o;
  logic [31:0] sec_rdata_o, ns_rdata_o;
  logic [3:0]  sec_count_o;
  logic [2:0]  ns_count_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] sq[$], nq[$];
  bit refill_m = 1'b0, err_m = 1'b0;
  logic [31:0] seq_word = 32'hA500_0000;

  always #4 clk = ~clk;

  rand_dist_fifos dut (
    .clk_i(clk), .rst_ni(rst_ni), .err_i(err_i),
    .prod_valid_i(prod_valid_i), .prod_data_i(prod_data_i), .prod_ready_o(prod_ready_o),
    .sec_rd_i(sec_rd_i), .sec_rdata_o(sec_rdata_o), .sec_count_o(sec_count_o), .sec_err_o(sec_err_o),
    .ns_rd_i(ns_rd_i), .ns_rdata_o(ns_rdata_o), .ns_count_o(ns_count_o), .ns_err_o(ns_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_active();
    return refill_m || (sq.size() < 4);
  endfunction

  function automatic bit m_ready();
    if (err_m || err_i) return 1'b0;
    return m_active() ? (sq.size() < 8) : (nq.size() < 4);
  endfunction

  task automatic cmp_all();
    chk("R8 ready", {31'd0, prod_ready_o}, {31'd0, m_ready()});
    chk("R1 sec count", {28'd0, sec_count_o}, sq.size());
    chk("R2 ns count", {29'd0, ns_count_o}, nq.size());
    chk("R3/R4 sec window", sec_rdata_o, sq.size() ? sq[0] : 32'd0);
    chk("R3/R4 ns window", ns_rdata_o, nq.size() ? nq[0] : 32'd0);
    chk("R9 sec err", {31'd0, sec_err_o}, {31'd0, err_m});
    chk("R9 ns err", {31'd0, ns_err_o}, {31'd0, err_m});
  endtask

  task automatic step(input bit v, input bit sr, input bit nr, input bit e);
    bit act, rdy;
    @(negedge clk);
    prod_valid_i = v; sec_rd_i = sr; ns_rd_i = nr; err_i = e;
    prod_data_i = seq_word;
    #1;
    cmp_all();
    act = m_active();
    rdy = m_ready();
    if (e || err_m) begin
      err_m = 1'b1; sq.delete(); nq.delete(); refill_m = 1'b0;
    end else begin
      if (sr && sq.size() > 0) void'(sq.pop_front());
      if (nr && nq.size() > 0) void'(nq.pop_front());
      if (v && rdy) begin
        if (act) sq.push_back(seq_word); else nq.push_back(seq_word);
        seq_word = seq_word * 32'd1103515245 + 32'd12345;
      end
      refill_m = act && (sq.size() != 8);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; prod_valid_i = 0; sec_rd_i = 0; ns_rd_i = 0; err_i = 0;
    sq.delete(); nq.delete(); refill_m = 0; err_m = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 sec count", {28'd0, sec_count_o}, 0);
    chk("R10 ns count", {29'd0, ns_count_o}, 0);
    chk("R10 err", {30'd0, sec_err_o, ns_err_o}, 0);
    chk("R10 ready", {31'd0, prod_ready_o}, 1);
    chk("R10 windows", sec_rdata_o | ns_rdata_o, 0);

    repeat (8) step(1, 0, 0, 0);
    chk("R5 secure filled first", {28'd0, sec_count_o}, 8);
    chk("R5 ns starved", {29'd0, ns_count_o}, 0);
    repeat (4) step(1, 0, 0, 0);
    chk("R7 ns filled after secure full", {29'd0, ns_count_o}, 4);
    step(1, 0, 0, 0);
    chk("R8 both full nothing taken", {25'd0, sec_count_o, ns_count_o}, {25'd0, 4'd8, 3'd4});

    repeat (4) step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    chk("R8 ns full at sec=4 no accept", {25'd0, sec_count_o, ns_count_o}, {25'd0, 4'd4, 3'd4});
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    chk("R7 sec not topped at 4", {28'd0, sec_count_o}, 4);
    chk("R7 word to ns", {29'd0, ns_count_o}, 4);

    step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    repeat (5) step(1, 0, 0, 0);
    chk("R6 refill ran to full", {28'd0, sec_count_o}, 8);
    chk("R6 ns held during refill", {29'd0, ns_count_o}, 2);
    repeat (2) step(1, 0, 0, 0);
    chk("R7 ns refilled", {29'd0, ns_count_o}, 4);

    repeat (9) step(0, 1, 0, 0);
    chk("R4 empty read keeps count", {28'd0, sec_count_o}, 0);
    chk("R4 empty window zero", sec_rdata_o, 0);
    repeat (5) step(0, 0, 1, 0);
    chk("R4 ns empty", {29'd0, ns_count_o}, 0);

    for (int i = 0; i < 120; i++)
      step(((i * 7) % 5) != 0, ((i * 3) % 4) == 0, ((i * 5) % 3) == 0, 0);

    repeat (6) step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    chk("R9 flags set", {30'd0, sec_err_o, ns_err_o}, 3);
    chk("R9 flushed", {25'd0, sec_count_o, ns_count_o}, 0);
    repeat (3) step(1, 1, 1, 0);
    chk("R9 sticky and blocked", {25'd0, sec_count_o, ns_count_o}, 0);
    chk("R9 flags held", {30'd0, sec_err_o, ns_err_o}, 3);

    do_reset();
    chk("R10 err cleared by reset", {30'd0, sec_err_o, ns_err_o}, 0);
    repeat (3) step(1, 0, 0, 0);
    chk("R5 after reset to secure", {28'd0, sec_count_o}, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule